// File: doc/BRIEF.md
# Two-Lane Serial Write Target

This block is the receiving end of a two-wire serial write bus. A master holds a request line high for a whole frame and moves two bits per clock on a pair of data lanes. The target turns that bit-pair stream back into a register write. The first cycle of a frame carries a write flag on lane 0 and the lowest address bit on lane 1. The next cycles carry the remaining address bits in pairs, lowest pair first. The last cycles carry the data word in pairs, lowest pair first. A static mode input selects either a 32-bit or an 8-bit data word.

When request drops, the target compares the number of cycles it counted with the frame length that the selected width requires. It commits the write only when the two match and the write flag was set. A commit is a single-cycle strobe that presents the address and data to an attached register array. An acknowledge pulse goes back to the master on the next cycle. Frames of the wrong length and frames without the write flag leave no trace at the outputs.

Top module: `pairbus_wr_target`

## Requirements
- R1: After reset, the write strobe and acknowledge are low and the address and data outputs are zero.
- R2: A frame whose lane 0 is low in its first cycle produces no strobe and no acknowledge.
- R3: Address bit 0 is taken from lane 1 in the first cycle of the frame.
- R4: Address bits 16..1 arrive over the next 8 cycles. Cycle k (1..8) carries bits {2k, 2k-1}, with lane 1 holding the higher bit.
- R5: In 32-bit mode (mode input 1), data arrives over 16 cycles after the address. Data cycle j (0..15) carries bits {2j+1, 2j}, with lane 1 holding the higher bit.
- R6: In 8-bit mode (mode input 0), data arrives over 4 cycles in the same pair order. Data output bits 31..8 are zero on the strobe, even if an earlier 32-bit frame left other values behind.
- R7: A write frame commits when request was high for exactly 25 cycles (32-bit mode) or 13 cycles (8-bit mode). The strobe is high in the second cycle after the last request-high cycle, and address and data are valid with it.
- R8: A frame that ends before the required count produces no strobe and no acknowledge.
- R9: A frame that stays high past the required count produces no strobe and no acknowledge.
- R10: Acknowledge is a single-cycle pulse in the cycle right after the strobe.
- R11: A new frame may start one cycle after request falls, and both frames commit correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide_i | input | 1 | Static width select: 1 = 32-bit data, 0 = 8-bit data |
| req_i | input | 1 | Frame request from the master |
| lane_i | input | 2 | Bit-pair data lanes |
| wr_stb_o | output | 1 | One-cycle write strobe to the register array |
| wr_addr_o | output | 17 | Write address, valid with the strobe |
| wr_data_o | output | 32 | Write data, valid with the strobe |
| ack_o | output | 1 | One-cycle acknowledge to the master |

## Verification
The bench builds the block with its default parameters: a 17-bit address, a 32-bit wide word and an 8-bit narrow word. These give frames of exactly 25 and 13 cycles. At these lengths every address pair position and every data pair position in both modes is reached. The off-by-one lengths on both sides of each count are also reached, as is the counter saturation for overlong frames. A frame that follows another after a single low cycle is reached too, as is an 8-bit frame after a 32-bit frame that leaves stale upper data bits behind.

// File: rtl/pairbus_wr_pkg.sv
package pairbus_wr_pkg;

  typedef enum logic [1:0] {
    PH_HEAD,
    PH_ADDR,
    PH_DATA,
    PH_OVER
  } phase_e;

  function automatic int unsigned frame_cycles(int unsigned addr_w, int unsigned data_w);
    return 1 + (addr_w - 1) / 2 + data_w / 2;
  endfunction

endpackage

// File: rtl/pairbus_frame_counter.sv
module pairbus_frame_counter #(
  parameter int unsigned MAX_CNT = 26,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_end_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = req_i || (cnt_q != '0);
    if (!req_i)
      cnt_d = '0;
    else if (cnt_q != CNT_TOP)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign cnt_o       = cnt_q;
  assign frame_end_o = !req_i && (cnt_q != '0);

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R9
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/pairbus_beat_collector.sv
module pairbus_beat_collector
  import pairbus_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        lane_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              wr_flag_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned ADDR_BEATS = (ADDR_W - 1) / 2;
  localparam int unsigned DATA_BEATS = DATA_W / 2;
  localparam int unsigned DATA_FIRST = 1 + ADDR_BEATS;
  localparam int unsigned DATA_LAST  = DATA_FIRST + DATA_BEATS;

  phase_e phase;
  logic   head_en;

  always_comb begin
    if (cnt_i == '0)
      phase = PH_HEAD;
    else if (cnt_i < CNT_W'(DATA_FIRST))
      phase = PH_ADDR;
    else if (cnt_i < CNT_W'(DATA_LAST))
      phase = PH_DATA;
    else
      phase = PH_OVER;
    head_en = req_i && (phase == PH_HEAD);
  end

  logic wr_flag_q;
  logic addr0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_flag_q <= 1'b0;
      addr0_q   <= 1'b0;
    end else if (head_en) begin
      wr_flag_q <= lane_i[0];
      addr0_q   <= lane_i[1];
    end
  end

  assign wr_flag_o = wr_flag_q;
  assign addr_o[0] = addr0_q;

  for (genvar g = 0; g < ADDR_BEATS; g++) begin : g_addr_pair
    logic       pair_en;
    logic [1:0] pair_q;
    assign pair_en = req_i && (phase == PH_ADDR) && (cnt_i == CNT_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pair_q <= 2'b00;
      else if (pair_en)
        pair_q <= lane_i;
    end
    assign addr_o[2*g+2 -: 2] = pair_q;
  end

  for (genvar g = 0; g < DATA_BEATS; g++) begin : g_data_pair
    logic       pair_en;
    logic [1:0] pair_q;
    assign pair_en = req_i && (phase == PH_DATA) && (cnt_i == CNT_W'(DATA_FIRST + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pair_q <= 2'b00;
      else if (pair_en)
        pair_q <= lane_i;
    end
    assign data_o[2*g+1 -: 2] = pair_q;
  end

  AST_HEAD_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && cnt_i == '0) |=> (addr_o[0] == $past(lane_i[1]))); // R3
  AST_HEAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && cnt_i == '0) |=> (wr_flag_o == $past(lane_i[0]))); // R2

endmodule

// File: rtl/pairbus_commit.sv
module pairbus_commit #(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NARROW_W   = 8,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned WIDE_LEN   = 25,
  parameter int unsigned NARROW_LEN = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide_i,
  input  logic              frame_end_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_flag_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              stb_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic              len_ok, fire;
  logic [DATA_W-1:0] data_sel;
  logic              stb_q, stb_d, ack_q, ack_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    len_ok   = (cnt_i == (mode_wide_i ? CNT_W'(WIDE_LEN) : CNT_W'(NARROW_LEN)));
    fire     = frame_end_i && len_ok && wr_flag_i;
    data_sel = mode_wide_i ? data_i : (data_i & NARROW_MASK);
    stb_d    = fire;
    ack_d    = stb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      addr_q <= addr_i;
      data_q <= data_sel;
    end
  end

  assign stb_o  = stb_q;
  assign ack_o  = ack_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R10
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R10
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !mode_wide_i) |-> ((data_q & ~NARROW_MASK) == '0)); // R6

endmodule

// File: rtl/pairbus_wr_target.sv
module pairbus_wr_target
  import pairbus_wr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide_i,
  input  logic              req_i,
  input  logic [1:0]        lane_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ack_o
);

  localparam int unsigned WIDE_LEN   = frame_cycles(ADDR_W, DATA_W);
  localparam int unsigned NARROW_LEN = frame_cycles(ADDR_W, NARROW_W);
  localparam int unsigned MAX_CNT    = WIDE_LEN + 1;
  localparam int unsigned CNT_W      = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0]  cnt;
  logic              frame_end;
  logic              wr_flag;
  logic [ADDR_W-1:0] col_addr;
  logic [DATA_W-1:0] col_data;

  pairbus_frame_counter #(
    .MAX_CNT (MAX_CNT),
    .CNT_W   (CNT_W)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .cnt_o       (cnt),
    .frame_end_o (frame_end)
  );

  pairbus_beat_collector #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_collector (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .lane_i    (lane_i),
    .cnt_i     (cnt),
    .wr_flag_o (wr_flag),
    .addr_o    (col_addr),
    .data_o    (col_data)
  );

  pairbus_commit #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NARROW_W   (NARROW_W),
    .CNT_W      (CNT_W),
    .WIDE_LEN   (WIDE_LEN),
    .NARROW_LEN (NARROW_LEN)
  ) u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wide_i (mode_wide_i),
    .frame_end_i (frame_end),
    .cnt_i       (cnt),
    .wr_flag_i   (wr_flag),
    .addr_i      (col_addr),
    .data_i      (col_data),
    .stb_o       (wr_stb_o),
    .ack_o       (ack_o),
    .addr_o      (wr_addr_o),
    .data_o      (wr_data_o)
  );

  AST_STB_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(!req_i)); // R7
  AST_ACK_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> ack_o); // R10
  AST_ACK_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(wr_stb_o)); // R10

endmodule

// File: tb/pairbus_wr_target_bench.sv
module pairbus_wr_target_bench;

  localparam int WIDE_LEN   = 25;
  localparam int NARROW_LEN = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wide_i = 1'b1;
  logic        req_i = 1'b0;
  logic [1:0]  lane_i = 2'b00;
  logic        wr_stb_o;
  logic [16:0] wr_addr_o;
  logic [31:0] wr_data_o;
  logic        ack_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pairbus_wr_target u_pairbus_wr_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wide_i (mode_wide_i),
    .req_i       (req_i),
    .lane_i      (lane_i),
    .wr_stb_o    (wr_stb_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .ack_o       (ack_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] beat_of(int k, logic wr, logic [16:0] a, logic [31:0] d, int dw);
    int j;
    if (k == 0) return {a[0], wr};
    if (k <= 8) return {a[2*k], a[2*k-1]};
    j = k - 9;
    if (j < dw / 2) return {d[2*j+1], d[2*j]};
    return 2'b10;
  endfunction

  function automatic logic [31:0] exp_data(bit wide, logic [31:0] d);
    return wide ? d : {24'h0, d[7:0]};
  endfunction

  task automatic send_frame(bit wide, logic wr, logic [16:0] a, logic [31:0] d, int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == 0) mode_wide_i = wide;
      req_i  = 1'b1;
      lane_i = beat_of(k, wr, a, d, wide ? 32 : 8);
    end
    @(negedge clk);
    req_i  = 1'b0;
    lane_i = 2'($urandom);
  endtask

  task automatic check_commit(bit fire, logic [16:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    if (fire) begin
      chk(wr_stb_o == 1'b1, "R7 strobe", 32'(wr_stb_o), 32'd1);
      chk(wr_addr_o == a, "R4 R3 address", 32'(wr_addr_o), 32'(a));
      chk(wr_data_o == d, "R5 R6 data", wr_data_o, d);
      chk(ack_o == 1'b0, "R10 ack early", 32'(ack_o), 32'd0);
      @(negedge clk);
      chk(ack_o == 1'b1 && wr_stb_o == 1'b0, "R10 ack pulse", {30'd0, ack_o, wr_stb_o}, 32'd2);
      @(negedge clk);
      chk(ack_o == 1'b0, "R10 ack single", 32'(ack_o), 32'd0);
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(wr_stb_o == 1'b0 && ack_o == 1'b0, tag, {30'd0, ack_o, wr_stb_o}, 32'd0);
      end
    end
  endtask

  task automatic run_frame(bit wide, logic wr, logic [16:0] a, logic [31:0] d, int len, string tag);
    int need;
    need = wide ? WIDE_LEN : NARROW_LEN;
    send_frame(wide, wr, a, d, len);
    check_commit(wr && len == need, a, exp_data(wide, d), tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(wr_stb_o == 0 && ack_o == 0, "R1 strobe/ack in reset", {30'd0, ack_o, wr_stb_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_addr_o == 0 && wr_data_o == 0, "R1 outputs zero", wr_data_o | 32'(wr_addr_o), 32'd0);

    // R3 R4 R5 R7: directed wide writes
    run_frame(1'b1, 1'b1, 17'h1ABCD, 32'hDEADBEEF, WIDE_LEN, "R7");
    run_frame(1'b1, 1'b1, 17'h00001, 32'h00000001, WIDE_LEN, "R3");
    run_frame(1'b1, 1'b1, 17'h10000, 32'h80000000, WIDE_LEN, "R4");
    // R6: narrow after wide leaves stale upper bits
    run_frame(1'b1, 1'b1, 17'h0AAAA, 32'hFFFFFFFF, WIDE_LEN, "R5");
    run_frame(1'b0, 1'b1, 17'h15555, 32'hFFFFFFA5, NARROW_LEN, "R6");
    // R2: read flag ignored
    run_frame(1'b1, 1'b0, 17'h01234, 32'h12345678, WIDE_LEN, "R2 no-write frame");
    run_frame(1'b0, 1'b0, 17'h01234, 32'h12, NARROW_LEN, "R2 no-write frame");
    chk(wr_addr_o == 17'h15555, "R2 address untouched", 32'(wr_addr_o), 32'h15555);
    // R8: short frames
    run_frame(1'b1, 1'b1, 17'h00F0F, 32'hCAFEF00D, WIDE_LEN - 1, "R8 short frame");
    run_frame(1'b1, 1'b1, 17'h00F0F, 32'hCAFEF00D, NARROW_LEN, "R8 short frame");
    run_frame(1'b0, 1'b1, 17'h00F0F, 32'h3C, NARROW_LEN - 1, "R8 short frame");
    // R9: long frames
    run_frame(1'b0, 1'b1, 17'h00F0F, 32'h3C, NARROW_LEN + 1, "R9 long frame");
    run_frame(1'b1, 1'b1, 17'h00F0F, 32'h3C, WIDE_LEN + 1, "R9 long frame");
    run_frame(1'b1, 1'b1, 17'h00F0F, 32'h3C, WIDE_LEN + 4, "R9 long frame");
    chk(wr_data_o == {24'h0, 8'hA5}, "R8 R9 data untouched", wr_data_o, 32'hA5);

    // R11: back-to-back frames with one low cycle between
    send_frame(1'b1, 1'b1, 17'h1F00F, 32'h0BADCAFE, WIDE_LEN);
    fork
      send_frame(1'b1, 1'b1, 17'h00FF0, 32'h600DF00D, WIDE_LEN);
      check_commit(1'b1, 17'h1F00F, 32'h0BADCAFE, "R11");
    join
    check_commit(1'b1, 17'h00FF0, 32'h600DF00D, "R11 second frame");

    // constrained random frames
    for (int n = 0; n < 80; n++) begin
      bit          wide;
      logic        wr;
      int          len, pick;
      logic [16:0] a;
      logic [31:0] d;
      wide = 1'($urandom);
      wr   = ($urandom % 10) != 0;
      a    = 17'($urandom);
      d    = $urandom;
      len  = wide ? WIDE_LEN : NARROW_LEN;
      pick = $urandom % 8;
      if (pick == 0) len = len - 1 - ($urandom % 3);
      else if (pick == 1) len = len + 1 + ($urandom % 3);
      run_frame(wide, wr, a, d, len, "R8 R9 R2 random reject");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule